// File: doc/BRIEF.md
# Message-Signalled Interrupt Doorbell Frame

This block sits on a simple register bus and converts message-signalled interrupt writes into single-cycle pulses on a bank of peripheral interrupt lines. A device signals an interrupt by writing an interrupt number into the doorbell register. The frame subtracts the first interrupt number it owns, checks that the result falls inside its range of lines, and raises the matching line for exactly one clock. Numbers outside that range are dropped without a response.

Software finds the frame's range through a type register. It packs the first owned interrupt number and the number of lines into one word. A fixed identification register and a read-as-zero identification window complete the 4 KB frame. Reads return data one cycle after the read strobe. The first owned line (`BASE_SPI`) and the line count (`NUM_LINES`) are elaboration parameters. Elaboration stops if the count exceeds 128, or if `BASE_SPI + 32 + NUM_LINES` exceeds 1020.

Top module: `msi_doorbell_frame`

## Requirements
- R1: While reset is high and on the first cycle after it, `irq_pulse` is all zero and `bus_rdata` is zero.
- R2: A read at offset 0x008 with `bus_size` = 4 returns `((BASE_SPI + 32) << 16) | NUM_LINES` on `bus_rdata` in the cycle after the read strobe.
- R3: A 4-byte read at offset 0xFCC returns 0x0510_0000 (product code 0x51 in bits 27:20, every other bit zero).
- R4: Every 4-byte read at an offset from 0xFD0 through 0xFFF returns zero.
- R5: A read at any offset other than 0x008, 0xFCC or the identification window returns zero. A write to any offset other than 0x040 raises no line.
- R6: A write at offset 0x040 with `bus_size` of 2 or 4 takes `bus_wdata[9:0]` as an interrupt ID. If `ID - (BASE_SPI + 32)` lies between 0 and `NUM_LINES - 1`, exactly that bit of `irq_pulse` is high for the single cycle after the write.
- R7: A doorbell ID below `BASE_SPI + 32`, or at or above `BASE_SPI + 32 + NUM_LINES`, raises no line. Bits 31:10 of the write data have no effect on which line is raised.
- R8: A read whose `bus_size` is not 4 (the size encodes the byte count: 1, 2 or 4) returns zero, even at the type or identification offset.
- R9: A write whose `bus_size` is neither 2 nor 4 is ignored and raises no line.
- R10: Doorbell writes on consecutive cycles each produce their own one-cycle pulse, in the order they were written.
- R11: Bits of `irq_pulse` at index `NUM_LINES` and above never go high.
- R12: `bus_rdata` changes only in the cycle after a read strobe. Between reads it holds the last value read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset within the 4 KB frame |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4) |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| irq_pulse | output | 128 | One-cycle interrupt pulses, one bit per line |

## Verification
A wrong ID offset or range bound shows up as a pulse on a neighbouring line, or as a pulse that is missing or extra. It appears on `irq_pulse` one cycle after the doorbell write, so the IDs on both edges of the range are driven. A stuck pulse register shows as a bit that is high for two cycles, or as two bits high together when back-to-back writes arrive. Errors in read selection or in holding read data appear on `bus_rdata` the cycle after a read, or during the idle cycles between reads.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

  localparam int FRAME_AW   = 12;
  localparam int DATA_W     = 32;
  localparam int INTID_W    = 10;
  localparam int SPI_FIRST  = 32;
  localparam int INTID_CEIL = 1020;
  localparam int LINE_CAP   = 128;

  localparam logic [FRAME_AW-1:0] OFS_TYPE     = 12'h008;
  localparam logic [FRAME_AW-1:0] OFS_DOORBELL = 12'h040;
  localparam logic [FRAME_AW-1:0] OFS_IDENT    = 12'hFCC;
  localparam logic [FRAME_AW-1:0] OFS_IDWIN_LO = 12'hFD0;

  localparam logic [7:0] PRODUCT_CODE = 8'h51;

  typedef logic [INTID_W:0] id_off_t;

  typedef struct packed {
    logic hit_type;
    logic hit_ident;
    logic hit_idwin;
    logic hit_doorbell;
    logic rd_size_ok;
    logic wr_size_ok;
  } frame_dec_t;

  // Discovery word: first owned interrupt number in the upper half, line count below.
  function automatic logic [DATA_W-1:0] type_word(input int unsigned base, input int unsigned num);
    logic [DATA_W-1:0] first;
    first = DATA_W'(base + SPI_FIRST);
    return (first << 16) | DATA_W'(num);
  endfunction

  function automatic logic [DATA_W-1:0] ident_word();
    return {4'h0, PRODUCT_CODE, 20'h0_0000};
  endfunction

  // Signed-by-borrow distance of an ID from the first owned interrupt number.
  function automatic id_off_t id_to_offset(input logic [INTID_W-1:0] id, input int unsigned base);
    return {1'b0, id} - id_off_t'(base + SPI_FIRST);
  endfunction

  function automatic logic offset_in_range(input id_off_t off, input int unsigned num);
    return !off[INTID_W] && (off < id_off_t'(num));
  endfunction

  function automatic logic [LINE_CAP-1:0] live_mask(input int unsigned num);
    logic [LINE_CAP-1:0] m;
    m = '0;
    for (int i = 0; i < LINE_CAP; i++) begin
      if (i < int'(num)) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/msi_frame_decode.sv
module msi_frame_decode
  import msi_frame_pkg::*;
(
  input  logic [FRAME_AW-1:0] addr,
  input  logic [2:0]          size,
  output frame_dec_t          dec
);

  always_comb begin
    dec.hit_type     = (addr == OFS_TYPE);
    dec.hit_ident    = (addr == OFS_IDENT);
    dec.hit_idwin    = (addr >= OFS_IDWIN_LO);
    dec.hit_doorbell = (addr == OFS_DOORBELL);
    dec.rd_size_ok   = (size == 3'd4);
    dec.wr_size_ok   = (size == 3'd2) || (size == 3'd4);
  end

endmodule

// File: rtl/msi_doorbell_xlate.sv
module msi_doorbell_xlate
  import msi_frame_pkg::*;
#(
  parameter int unsigned BASE_SPI  = 0,
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned OUT_LINES = 128
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fire,
  input  logic [INTID_W-1:0]    intid,
  output logic [OUT_LINES-1:0]  pulse
);

  localparam int IDX_W = (OUT_LINES > 1) ? $clog2(OUT_LINES) : 1;
  localparam logic [LINE_CAP-1:0] MASK_FULL = live_mask(NUM_LINES);
  localparam logic [OUT_LINES-1:0] LIVE = MASK_FULL[OUT_LINES-1:0];

  id_off_t              off;
  logic                 in_range;
  logic                 accept;
  logic [IDX_W-1:0]     line_idx;
  logic [OUT_LINES-1:0] pulse_d;
  logic [OUT_LINES-1:0] pulse_q;

  assign off      = id_to_offset(intid, BASE_SPI);
  assign in_range = offset_in_range(off, NUM_LINES);
  assign accept   = fire && in_range;
  assign line_idx = off[IDX_W-1:0];

  always_comb begin
    pulse_d = '0;
    if (accept) pulse_d[line_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= '0;
    else     pulse_q <= pulse_d & LIVE;
  end

  assign pulse = pulse_q;

  // R6: an accepted doorbell leaves exactly one line high on the next cycle
  a_r6_one_line: assert property (@(posedge clk) disable iff (rst)
    accept |=> ($countones(pulse_q) == 1));

  // R6: the raised line is the one the ID selected
  a_r6_right_line: assert property (@(posedge clk) disable iff (rst)
    accept |=> pulse_q[$past(line_idx)]);

  // R7 / R10: without an accepted doorbell nothing is raised, so no pulse outlives its cycle
  a_r7_drop_quiet: assert property (@(posedge clk) disable iff (rst)
    !accept |=> (pulse_q == '0));

endmodule

// File: rtl/msi_read_mux.sv
module msi_read_mux
  import msi_frame_pkg::*;
#(
  parameter int unsigned BASE_SPI  = 0,
  parameter int unsigned NUM_LINES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  frame_dec_t        dec,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [DATA_W-1:0] TYPE_VAL  = type_word(BASE_SPI, NUM_LINES);
  localparam logic [DATA_W-1:0] IDENT_VAL = ident_word();

  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    sel = '0;
    if (dec.rd_size_ok) begin
      if (dec.hit_type)       sel = TYPE_VAL;
      else if (dec.hit_ident) sel = IDENT_VAL;
      else                    sel = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= sel;
  end

  assign rdata = rdata_q;

  // R2: a full-width read of the type offset returns the discovery word
  a_r2_type_read: assert property (@(posedge clk) disable iff (rst)
    (rd && dec.rd_size_ok && dec.hit_type) |=> (rdata_q == TYPE_VAL));

  // R8: a read of the wrong size returns zero
  a_r8_bad_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd && !dec.rd_size_ok) |=> (rdata_q == '0));

  // R12: read data holds while no read is made
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata_q));

endmodule

// File: rtl/msi_doorbell_frame.sv
module msi_doorbell_frame
  import msi_frame_pkg::*;
#(
  parameter int unsigned BASE_SPI  = 0,
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned OUT_LINES = 128
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [11:0]           bus_addr,
  input  logic [31:0]           bus_wdata,
  input  logic [2:0]            bus_size,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  output logic [31:0]           bus_rdata,
  output logic [OUT_LINES-1:0]  irq_pulse
);

  frame_dec_t dec;
  logic       doorbell_fire;

  initial begin
    assert (NUM_LINES >= 1 && NUM_LINES <= LINE_CAP && NUM_LINES <= OUT_LINES)
      else $fatal(1, "line count %0d outside 1..%0d", NUM_LINES, LINE_CAP);
    assert (BASE_SPI + SPI_FIRST + NUM_LINES <= INTID_CEIL)
      else $fatal(1, "owned interrupt range ends above %0d", INTID_CEIL);
  end

  msi_frame_decode u_decode (
    .addr (bus_addr),
    .size (bus_size),
    .dec  (dec)
  );

  assign doorbell_fire = bus_wr && dec.hit_doorbell && dec.wr_size_ok;

  msi_doorbell_xlate #(
    .BASE_SPI  (BASE_SPI),
    .NUM_LINES (NUM_LINES),
    .OUT_LINES (OUT_LINES)
  ) u_xlate (
    .clk   (clk),
    .rst   (rst),
    .fire  (doorbell_fire),
    .intid (bus_wdata[INTID_W-1:0]),
    .pulse (irq_pulse)
  );

  msi_read_mux #(
    .BASE_SPI  (BASE_SPI),
    .NUM_LINES (NUM_LINES)
  ) u_read (
    .clk   (clk),
    .rst   (rst),
    .rd    (bus_rd),
    .dec   (dec),
    .rdata (bus_rdata)
  );

  // R9: a write of an unsupported size raises nothing
  a_r9_bad_write_size: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !(bus_size == 3'd2 || bus_size == 3'd4)) |=> (irq_pulse == '0));

  // R5: a write away from the doorbell offset raises nothing
  a_r5_other_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr != OFS_DOORBELL) |=> (irq_pulse == '0));

endmodule

// File: tb/msi_doorbell_frame_test.sv
module msi_doorbell_frame_test;

  localparam int TB_BASE = 16;
  localparam int TB_NUM  = 40;
  localparam int FIRST   = TB_BASE + 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [2:0]   bus_size = '0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [31:0]  bus_rdata;
  logic [127:0] irq_pulse;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int           tag;
    logic [127:0] pulse;
    logic [31:0]  rdata;
    string        req;
  } item_t;

  item_t       sb[$];
  logic [31:0] rd_hold = '0;

  msi_doorbell_frame #(.BASE_SPI(TB_BASE), .NUM_LINES(TB_NUM), .OUT_LINES(128)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_size(bus_size), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model_pulse(input logic [11:0] a, input logic [31:0] d,
                                               input logic [2:0] sz, input logic w);
    int id;
    id = int'(d[9:0]);
    if (w && a == 12'h040 && (sz == 3'd2 || sz == 3'd4) && id >= FIRST && id < FIRST + TB_NUM)
      return 128'(1) << (id - FIRST);
    return '0;
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a, input logic [2:0] sz);
    if (sz != 3'd4) return '0;
    if (a == 12'h008) return (32'(FIRST) << 16) | 32'(TB_NUM);
    if (a == 12'hFCC) return 32'h0510_0000;
    return '0;
  endfunction

  task automatic drive(input logic [11:0] a, input logic [31:0] d, input logic [2:0] sz,
                       input logic w, input logic r, input string req);
    item_t it;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = w; bus_rd = r;
    if (r) rd_hold = model_read(a, sz);
    it.tag = cyc; it.pulse = model_pulse(a, d, sz, w); it.rdata = rd_hold; it.req = req;
    sb.push_back(it);
  endtask

  task automatic idle(input string req);
    drive(12'h000, 32'h0, 3'd0, 1'b0, 1'b0, req);
  endtask

  // Monitor: compares each result one cycle after its stimulus.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0 && sb[0].tag == cyc - 1) begin
        item_t it;
        it = sb.pop_front();
        check({it.req, " pulse"}, irq_pulse, it.pulse);
        check("R11 upper lines", {irq_pulse[127:TB_NUM], {TB_NUM{1'b0}}}, '0);
        check({it.req, " rdata"}, {96'h0, bus_rdata}, {96'h0, it.rdata});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset pulse", irq_pulse, '0);
    check("R1 reset rdata", {96'h0, bus_rdata}, '0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 after reset pulse", irq_pulse, '0);
    check("R1 after reset rdata", {96'h0, bus_rdata}, '0);

    drive(12'h008, 0, 3'd4, 1'b0, 1'b1, "R2 type read");
    idle("R12 hold after type");
    idle("R12 hold again");
    drive(12'hFCC, 0, 3'd4, 1'b0, 1'b1, "R3 ident read");
    drive(12'hFD0, 0, 3'd4, 1'b0, 1'b1, "R4 idwin low");
    drive(12'h008, 0, 3'd4, 1'b0, 1'b1, "R2 type reread");
    drive(12'hFFC, 0, 3'd4, 1'b0, 1'b1, "R4 idwin high");
    drive(12'h100, 0, 3'd4, 1'b0, 1'b1, "R5 unknown read");
    drive(12'h008, 0, 3'd2, 1'b0, 1'b1, "R8 short type read");
    drive(12'hFCC, 0, 3'd1, 1'b0, 1'b1, "R8 byte ident read");

    drive(12'h040, FIRST, 3'd4, 1'b1, 1'b0, "R6 lowest line");
    idle("R6 pulse ends");
    drive(12'h040, FIRST + TB_NUM - 1, 3'd4, 1'b1, 1'b0, "R6 highest line");
    idle("R6 idle");
    drive(12'h040, FIRST + 5, 3'd2, 1'b1, 1'b0, "R6 halfword doorbell");
    drive(12'h040, FIRST + TB_NUM, 3'd4, 1'b1, 1'b0, "R7 one above range");
    drive(12'h040, FIRST - 1, 3'd4, 1'b1, 1'b0, "R7 one below range");
    drive(12'h040, 32'h0000_03FF, 3'd4, 1'b1, 1'b0, "R7 max id");
    drive(12'h040, 32'hFFFF_FC00 | (FIRST + 2), 3'd4, 1'b1, 1'b0, "R7 upper bits ignored");
    drive(12'h040, FIRST + 7, 3'd1, 1'b1, 1'b0, "R9 byte write");
    drive(12'h040, FIRST + 7, 3'd3, 1'b1, 1'b0, "R9 odd size write");
    drive(12'h044, FIRST + 7, 3'd4, 1'b1, 1'b0, "R5 write wrong offset");
    drive(12'h008, FIRST + 7, 3'd4, 1'b1, 1'b0, "R5 write type offset");

    drive(12'h040, FIRST + 10, 3'd4, 1'b1, 1'b0, "R10 burst first");
    drive(12'h040, FIRST + 11, 3'd4, 1'b1, 1'b0, "R10 burst second");
    drive(12'h040, FIRST + 10, 3'd4, 1'b1, 1'b0, "R10 burst repeat");
    drive(12'h040, FIRST + 30, 3'd2, 1'b1, 1'b1, "R10 burst with read");
    idle("R10 burst end");

    for (int k = 0; k < TB_NUM + 4; k++) begin
      drive(12'h040, FIRST - 2 + k, 3'd4, 1'b1, 1'b0, "R6 sweep");
    end
    drive(12'hFCC, 0, 3'd4, 1'b0, 1'b1, "R3 ident final");
    idle("R12 final hold");
    idle("R12 final hold");
    idle("R12 final hold");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule